// File: doc/BRIEF.md
# Dual-Ratio Fractional Clock Divider

This block derives a slow core clock from a fast crystal clock. It has two integer divisors, A and B. Divisor A runs for a programmable number of output periods, then divisor B runs for its own programmable number of periods, and the pattern repeats. The average output frequency therefore lies between the two plain integer ratios. With divisors 733 and 732 and repeat counts 8 and 11, the output averages about 32.768 kHz from a 24 MHz crystal.

There are two other modes. In single mode only divisor A is used. In bypass mode the input clock is passed through unchanged. Two 32-bit configuration words drive the block directly. Register decoding, clock gating cells and PLLs sit outside it.

The block has two outputs for downstream logic:
- A clock-enable pulse, one input cycle wide, at the start of every output period.
- A divided clock level with roughly 50 % duty.

Top module: `dual_ratio_div`

## Requirements
- R1: While reset is asserted and just after it, `tick_o`, `lvl_o` and `active_o` are all 0.
- R2: Word 0 bit 31 is input enable and bit 30 is output enable. With both set, dual mode off (word 0 bit 28 = 0) and bypass off (word 1 bit 24 = 0), `tick_o` pulses once every NA input cycles. NA is the word 0 field [11:0] plus one, since every divisor and repeat field is stored as its value minus one.
- R3: In dual mode, divisor A (word 0 [11:0] + 1) is used for MA output periods (word 1 [11:0] + 1). Divisor B (word 0 [23:12] + 1) is then used for MB periods (word 1 [23:12] + 1), and the pattern repeats. The first period after enabling always uses divisor A.
- R4: Within each period of length N, `lvl_o` is high for the first floor(N/2) input cycles, starting in the cycle where `tick_o` pulses, and low for the rest. With N = 1, `lvl_o` stays low and `tick_o` is high every cycle.
- R5: When output enable is clear at a clock edge, both outputs are 0 in the following cycle. Once both enables are set again, the sequence restarts at the start of a divisor-A period, with `tick_o` high in the first cycle after the enabling edge.
- R6: While input enable is clear, no other field setting (output enable, bypass, mode or divisors) produces any activity on `tick_o` or `lvl_o`.
- R7: `active_o` equals the OR of the two enable bits as sampled at the previous clock edge.
- R8: With bypass set and both enables set, from the cycle after the enabling edge `lvl_o` follows the input clock and `tick_o` is high in every cycle.
- R9: With NA = 733, NB = 732, MA = 8 and MB = 11, exactly 19 pulses occur in the first 13916 input cycles, and the 20th pulse falls in cycle 13916.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast crystal clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg0_i | input | 32 | Configuration word 0: divisors A/B, dual mode, output and input enables |
| cfg1_i | input | 32 | Configuration word 1: repeat counts A/B, bypass |
| tick_o | output | 1 | One-cycle enable pulse at the start of each output period |
| lvl_o | output | 1 | Divided clock level |
| active_o | output | 1 | High when either enable bit was set at the last edge |

## Verification
The main function is swept over every combination of divisors 1 to 4 and repeat counts 1 to 3 in dual mode, and over divisors 1 to 8 in single mode. Pulse positions and level shape are predicted cycle by cycle from the stated period arithmetic. The dual sweep separates a correct phase switch from off-by-one errors in either repeat counter. It also catches a swapped divisor or a wrong starting phase. The single sweep with odd divisors exposes rounding errors in the duty split. A disable issued in the middle of phase B, followed by re-enabling, shows whether the restart really returns to phase A. The long reference setting checks the averaged period count over one full A/B cycle.

// File: rtl/drd_pkg.sv
`timescale 1ns/1ps
package drd_pkg;
    localparam int WORD_W   = 32;
    localparam int DIV_W    = 12;
    localparam int REP_W    = 12;
    localparam int DIVA_LSB = 0;
    localparam int DIVB_LSB = DIVA_LSB + DIV_W;
    localparam int REPA_LSB = 0;
    localparam int REPB_LSB = REPA_LSB + REP_W;
    localparam int DUAL_BIT = 28;
    localparam int OEN_BIT  = 30;
    localparam int IEN_BIT  = 31;
    localparam int BYP_BIT  = 24;

    typedef struct packed {
        logic [DIV_W-1:0] div_a;
        logic [DIV_W-1:0] div_b;
        logic [REP_W-1:0] rep_a;
        logic [REP_W-1:0] rep_b;
        logic             dual;
        logic             bypass;
    } drd_cfg_t;

    function automatic drd_cfg_t unpack_cfg(input logic [WORD_W-1:0] w0,
                                            input logic [WORD_W-1:0] w1);
        drd_cfg_t c;
        c.div_a  = w0[DIVA_LSB +: DIV_W];
        c.div_b  = w0[DIVB_LSB +: DIV_W];
        c.rep_a  = w1[REPA_LSB +: REP_W];
        c.rep_b  = w1[REPB_LSB +: REP_W];
        c.dual   = w0[DUAL_BIT];
        c.bypass = w1[BYP_BIT];
        return c;
    endfunction
endpackage

// File: rtl/drd_cfg_hold.sv
`timescale 1ns/1ps
module drd_cfg_hold
    import drd_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [WORD_W-1:0] word0_i,
    input  logic [WORD_W-1:0] word1_i,
    output drd_cfg_t          cfg_o,
    output logic              run_o,
    output logic              active_o
);
    typedef struct packed {
        drd_cfg_t cfg;
        logic     active;
    } hold_t;

    hold_t h_d, h_q;
    logic  in_en, out_en;

    assign in_en  = word0_i[IEN_BIT];
    assign out_en = word0_i[OEN_BIT];

    always_comb begin
        h_d        = h_q;
        h_d.active = in_en | out_en;
        if (in_en) begin
            h_d.cfg = unpack_cfg(word0_i, word1_i);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    assign cfg_o    = h_q.cfg;
    assign run_o    = in_en & out_en;
    assign active_o = h_q.active;
endmodule

// File: rtl/drd_seq.sv
`timescale 1ns/1ps
module drd_seq
    import drd_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_a_i,
    input  logic [DIV_W-1:0] div_b_i,
    input  logic [REP_W-1:0] rep_a_i,
    input  logic [REP_W-1:0] rep_b_i,
    input  logic             dual_i,
    output logic             live_o,
    output logic [DIV_W-1:0] cnt_o,
    output logic [DIV_W-1:0] last_o
);
    typedef struct packed {
        logic             live;
        logic             phase_b;
        logic [DIV_W-1:0] cnt;
        logic [REP_W-1:0] rep;
    } seq_t;

    seq_t             s_d, s_q;
    logic [DIV_W-1:0] last_cnt;
    logic [REP_W-1:0] last_rep;

    always_comb begin
        last_cnt = (s_q.phase_b && dual_i) ? div_b_i : div_a_i;
        last_rep = s_q.phase_b ? rep_b_i : rep_a_i;
        s_d      = s_q;
        if (!run_i) begin
            s_d = '0;
        end else if (!s_q.live) begin
            s_d      = '0;
            s_d.live = 1'b1;
        end else if (s_q.cnt >= last_cnt) begin
            s_d.cnt = '0;
            if (!dual_i) begin
                s_d.phase_b = 1'b0;
                s_d.rep     = '0;
            end else if (s_q.rep >= last_rep) begin
                s_d.rep     = '0;
                s_d.phase_b = ~s_q.phase_b;
            end else begin
                s_d.rep = s_q.rep + 1'b1;
            end
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign live_o = s_q.live;
    assign cnt_o  = s_q.cnt;
    assign last_o = last_cnt;
endmodule

// File: rtl/drd_out.sv
`timescale 1ns/1ps
module drd_out
    import drd_pkg::*;
(
    input  logic             clk_i,
    input  logic             live_i,
    input  logic             bypass_i,
    input  logic [DIV_W-1:0] cnt_i,
    input  logic [DIV_W-1:0] last_i,
    output logic             tick_o,
    output logic             lvl_o
);
    localparam int LEN_W = DIV_W + 1;

    logic [LEN_W-1:0] per_len;
    logic [LEN_W-1:0] half_len;
    logic             high_part;

    always_comb begin
        per_len   = {1'b0, last_i} + LEN_W'(1);
        half_len  = per_len >> 1;
        high_part = {1'b0, cnt_i} < half_len;
        tick_o    = live_i & (bypass_i | (cnt_i == '0));
        lvl_o     = live_i & (bypass_i ? clk_i : high_part);
    end
endmodule

// File: rtl/dual_ratio_div.sv
`timescale 1ns/1ps
module dual_ratio_div
    import drd_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic [31:0] cfg0_i,
    input  logic [31:0] cfg1_i,
    output logic        tick_o,
    output logic        lvl_o,
    output logic        active_o
);
    drd_cfg_t         cfg;
    logic             run;
    logic             live;
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] last;

    drd_cfg_hold u_hold (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .word0_i  (cfg0_i),
        .word1_i  (cfg1_i),
        .cfg_o    (cfg),
        .run_o    (run),
        .active_o (active_o)
    );

    drd_seq u_seq (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (run),
        .div_a_i (cfg.div_a),
        .div_b_i (cfg.div_b),
        .rep_a_i (cfg.rep_a),
        .rep_b_i (cfg.rep_b),
        .dual_i  (cfg.dual),
        .live_o  (live),
        .cnt_o   (cnt),
        .last_o  (last)
    );

    drd_out u_out (
        .clk_i    (clk_i),
        .live_i   (live),
        .bypass_i (cfg.bypass),
        .cnt_i    (cnt),
        .last_i   (last),
        .tick_o   (tick_o),
        .lvl_o    (lvl_o)
    );
endmodule

// File: rtl/drd_chk.sv
`timescale 1ns/1ps
module drd_chk
    import drd_pkg::*;
(
    input logic             clk_i,
    input logic             rst_ni,
    input logic [31:0]      cfg0_i,
    input logic             tick_o,
    input logic             lvl_o,
    input logic             active_o,
    input logic             live,
    input logic [DIV_W-1:0] cnt,
    input logic [DIV_W-1:0] last,
    input logic             byp
);
    // R6: input enable clear at an edge leaves the outputs idle
    assert_in_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && !$past(cfg0_i[IEN_BIT])) |-> (!tick_o && !live));

    // R5: output enable clear at an edge forces both outputs low
    assert_out_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && !$past(cfg0_i[OEN_BIT])) |-> (!tick_o && !lvl_o));

    // R7: enabled indication follows the previous enable bits
    assert_active_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> (active_o == ($past(cfg0_i[IEN_BIT]) || $past(cfg0_i[OEN_BIT]))));

    // R5: every start of activity begins at the first cycle of a period
    assert_restart_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(live) |-> (cnt == '0));

    // R2: a divided pulse only follows a finished period
    assert_period_end_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_o && !byp && $past(live)) |-> ($past(cnt) >= $past(last)));
endmodule

bind dual_ratio_div drd_chk u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cfg0_i   (cfg0_i),
    .tick_o   (tick_o),
    .lvl_o    (lvl_o),
    .active_o (active_o),
    .live     (live),
    .cnt      (cnt),
    .last     (last),
    .byp      (cfg.bypass)
);

// File: tb/dual_ratio_div_tb_top.sv
`timescale 1ns/1ps
module dual_ratio_div_tb_top;
    logic        clk;
    logic        rst_n;
    logic [31:0] cfg0;
    logic [31:0] cfg1;
    logic        tick;
    logic        lvl;
    logic        active;
    int          n_tests;
    int          n_fail;
    bit          done;

    dual_ratio_div dut_i (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .cfg0_i   (cfg0),
        .cfg1_i   (cfg1),
        .tick_o   (tick),
        .lvl_o    (lvl),
        .active_o (active)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    function automatic logic [31:0] mk0(int na, int nb, bit dual, bit oen, bit ien);
        logic [11:0] a = 12'(na - 1);
        logic [11:0] b = 12'(nb - 1);
        return {ien, oen, 1'b0, dual, 4'b0, b, a};
    endfunction

    function automatic logic [31:0] mk1(int ma, int mb, bit byp);
        logic [11:0] a = 12'(ma - 1);
        logic [11:0] b = 12'(mb - 1);
        return {7'b0, byp, b, a};
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Compare tick/lvl each cycle with period arithmetic; enable was driven at the previous negedge.
    task automatic follow(int na, int nb, int ma, int mb, bit dual, int cycles, string req);
        int  p = 0;
        int  pos = 0;
        bit  ok = 1'b1;
        int  act = 0;
        int  exp = 0;
        for (int j = 0; j < cycles; j++) begin
            int  n;
            bit  et;
            bit  el;
            @(negedge clk);
            n  = (dual && ((p % (ma + mb)) >= ma)) ? nb : na;
            et = (pos == 0);
            el = (pos < n / 2);
            if (ok && (tick !== et || lvl !== el)) begin
                ok  = 1'b0;
                act = {tick, lvl};
                exp = {et, el};
                $display("  mismatch cycle %0d na=%0d nb=%0d ma=%0d mb=%0d", j, na, nb, ma, mb);
            end
            pos++;
            if (pos == n) begin
                pos = 0;
                p++;
            end
        end
        check(ok, req, act, exp);
    endtask

    task automatic start(int na, int nb, int ma, int mb, bit dual, bit byp);
        @(negedge clk);
        cfg0 = mk0(na, nb, dual, 1'b0, 1'b0);
        cfg1 = mk1(ma, mb, byp);
        @(negedge clk);
        cfg0 = mk0(na, nb, dual, 1'b1, 1'b1);
    endtask

    task automatic stop_all();
        @(negedge clk);
        cfg0 = 32'h0;
        @(negedge clk);
    endtask

    initial begin
        n_tests = 0;
        n_fail  = 0;
        done    = 1'b0;
        rst_n   = 1'b0;
        cfg0    = 32'h0;
        cfg1    = 32'h0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(tick === 1'b0 && lvl === 1'b0 && active === 1'b0, "R1 reset", {tick, lvl, active}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(tick === 1'b0 && lvl === 1'b0 && active === 1'b0, "R1 after reset", {tick, lvl, active}, 0);

        // R7: active indication
        cfg0 = mk0(3, 3, 1'b0, 1'b1, 1'b0);
        @(negedge clk);
        check(active === 1'b1, "R7 out only", active, 1);
        cfg0 = 32'h0;
        @(negedge clk);
        check(active === 1'b0, "R7 none", active, 0);
        cfg0 = mk0(3, 3, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        check(active === 1'b1 && tick === 1'b0, "R7 in only", {active, tick}, 2);

        // R6: input enable clear, everything else set including bypass
        cfg0 = mk0(2, 3, 1'b1, 1'b1, 1'b0);
        cfg1 = mk1(1, 1, 1'b1);
        begin
            bit ok = 1'b1;
            for (int j = 0; j < 8; j++) begin
                @(posedge clk);
                #5;
                if (tick !== 1'b0 || lvl !== 1'b0) ok = 1'b0;
                @(negedge clk);
                if (tick !== 1'b0 || lvl !== 1'b0) ok = 1'b0;
            end
            check(ok, "R6 input enable gates output", {tick, lvl}, 0);
        end

        // R2 and R4: single mode sweep
        for (int n = 1; n <= 8; n++) begin
            start(n, 5, 2, 2, 1'b0, 1'b0);
            follow(n, 5, 2, 2, 1'b0, 3 * n + 2, "R2/R4 single mode");
            stop_all();
        end

        // R3 and R4: dual mode sweep
        for (int a = 1; a <= 4; a++)
            for (int b = 1; b <= 4; b++)
                for (int ma = 1; ma <= 3; ma++)
                    for (int mb = 1; mb <= 3; mb++) begin
                        start(a, b, ma, mb, 1'b1, 1'b0);
                        follow(a, b, ma, mb, 1'b1, 2 * (a * ma + b * mb) + 2, "R3/R4 dual mode");
                        stop_all();
                    end

        // R5: stop in the middle of phase B, outputs go low, restart begins in phase A
        start(2, 5, 1, 2, 1'b1, 1'b0);
        repeat (4) @(negedge clk);
        cfg0 = mk0(2, 5, 1'b1, 1'b0, 1'b1);
        begin
            bit ok = 1'b1;
            for (int j = 0; j < 6; j++) begin
                @(negedge clk);
                if (tick !== 1'b0 || lvl !== 1'b0) ok = 1'b0;
            end
            check(ok, "R5 output disable holds low", {tick, lvl}, 0);
        end
        cfg0 = mk0(2, 5, 1'b1, 1'b1, 1'b1);
        follow(2, 5, 1, 2, 1'b1, 30, "R5 restart in phase A");
        stop_all();

        // R8: bypass passes the input clock
        start(4, 4, 1, 1, 1'b0, 1'b1);
        @(negedge clk);
        begin
            bit ok = 1'b1;
            for (int j = 0; j < 6; j++) begin
                if (tick !== 1'b1 || lvl !== 1'b0) ok = 1'b0;
                @(posedge clk);
                #5;
                if (tick !== 1'b1 || lvl !== 1'b1) ok = 1'b0;
                @(negedge clk);
            end
            check(ok, "R8 bypass", {tick, lvl}, 3);
        end
        stop_all();

        // R9: reference setting, count pulses over one full A/B cycle
        start(733, 732, 8, 11, 1'b1, 1'b0);
        begin
            int cnt_t = 0;
            for (int j = 0; j < 13916; j++) begin
                @(negedge clk);
                if (tick === 1'b1) cnt_t++;
            end
            check(cnt_t == 19, "R9 pulses per cycle", cnt_t, 19);
            @(negedge clk);
            check(tick === 1'b1, "R9 next cycle start", tick, 1);
        end
        stop_all();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule